// File: doc/BRIEF.md
# Deserializer Output Enable and Lock Sequencer

This block decides, every reference-clock cycle, what the parallel data outputs and the forwarded frame clock of a three-lane deserializer may show. It watches an asynchronous run pin, the level of the recovered frame clock, a fail-safe flag per data lane, a fail-safe flag for the clock lane, and the coding mode. From these it drives one output-enable for the whole output bank, a PLL run control, the gated data word and the gated clock.

After the run pin rises, the block holds every output low until it has counted a fixed number of frame-clock periods. It then passes data through. When the frame clock stops for longer than a programmable number of reference cycles, all outputs drop low. The lock count then starts again from zero at the next frame-clock edge. When the run pin is low, the output bank is released to high impedance and the PLL is stopped.

In plain (non-balanced) coding, a lane that reports fail-safe has its own seven outputs forced low. A fail-safe on the clock lane forces every output low. In balanced coding all fail-safe flags are ignored.

Top module: `rx_out_sequencer`

## Requirements
- R1: While rst_n is low and after its release with run_pin low, drive_en, pll_run, clk_out and every bit of par_dout are 0.
- R2: A fall of run_pin reaches drive_en = 0 and pll_run = 0 no later than the fourth rising clk edge after the change, which is within 100 ns at a 50 MHz reference. While drive_en is 0, par_dout and clk_out are 0.
- R3: After run_pin rises, pll_run and drive_en become 1, and par_dout and clk_out stay 0 until lock is declared.
- R4: Lock is declared on the LOCK_CYCLES-th rising edge of the frame clock seen while locking. From then on, par_dout equals par_din registered once, and clk_out follows the synchronised frame-clock level.
- R5: If no frame-clock rising edge is seen for stall_gap reference cycles (stall_gap must be 1 or more), par_dout and clk_out are forced to 0 while drive_en stays 1. A gap shorter than stall_gap has no effect on the outputs.
- R6: After a stall, the next frame-clock rising edge restarts locking with the count at zero, so a full LOCK_CYCLES edges must pass again before data is shown.
- R7: With bal_mode = 0, lane_fs[i] = 1 forces par_dout[7*i+6 : 7*i] to 0. The other lanes keep passing data.
- R8: With bal_mode = 0, clk_fs = 1 forces all of par_dout and clk_out to 0.
- R9: With bal_mode = 1, lane_fs and clk_fs have no effect on par_dout or clk_out.
- R10: A power-down followed by a new power-up needs a full new lock count before data is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_pin | input | 1 | Asynchronous run request; low means power down |
| fclk_lvl | input | 1 | Level of the recovered frame clock, asynchronous |
| bal_mode | input | 1 | 1 = balanced coding (fail-safe ignored), 0 = plain coding |
| lane_fs | input | LANES | Per-lane fail-safe flags, synchronous to clk |
| clk_fs | input | 1 | Clock-lane fail-safe flag, synchronous to clk |
| stall_gap | input | GAP_W | Reference cycles without a frame-clock edge that count as a stall |
| par_din | input | LANES*BITS | Deserialized word, synchronous to clk |
| par_dout | output | LANES*BITS | Gated data word |
| clk_out | output | 1 | Gated forwarded frame clock |
| drive_en | output | 1 | Output-bank enable; 0 means high impedance |
| pll_run | output | 1 | PLL run control |

## Verification
The run pin passes two synchroniser flops, the state register and the output register, so the bench samples drive_en and pll_run at the falling edge after the fourth rising edge that follows a change of the pin. Data and fail-safe changes appear one register later, and the bench checks them at the falling edge after the next rising edge. Lock and stall results depend on frame-clock edges that pass three flops of their own. For these the bench counts the edges it generates and samples only where the count lies well below or well above the threshold, so that the synchroniser delay cannot tip the result either way.

// File: rtl/rxseq_pkg.sv
// Shared types for the deserializer output sequencer.
package rxseq_pkg;
    // Sequencer states; only SEQ_RUN shows data.
    typedef enum logic [1:0] {
        SEQ_OFF     = 2'd0,
        SEQ_LOCKING = 2'd1,
        SEQ_RUN     = 2'd2,
        SEQ_STALL   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/rxseq_sync.sv
// Multi-flop synchroniser for one asynchronous bit.
// Assumes STAGES >= 2; the reset value is loaded into every flop.
module rxseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rxseq_edge_watch.sv
// Watches the recovered frame clock: synchronises its level, flags each
// rising edge and measures the gap since the last edge.
// Assumes gap_limit >= 1 and a frame clock slower than clk/2.
module rxseq_edge_watch #(
    parameter int STAGES = 2,
    parameter int GAP_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fclk_lvl,
    input  logic [GAP_W-1:0] gap_limit,
    output logic             fclk_s,
    output logic             rise,
    output logic             gap_over
);
    localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

    logic             prev_q;
    logic [GAP_W-1:0] gap_cnt;

    rxseq_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_fclk_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (fclk_lvl),
        .q     (fclk_s)
    );

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= fclk_s;
    end

    assign rise = fclk_s & ~prev_q;

    // Count reference cycles since the last rising edge, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || rise) gap_cnt <= '0;
        else if (gap_cnt != GAP_MAX)   gap_cnt <= gap_cnt + 1'b1;
    end

    assign gap_over = enable && !rise && (gap_cnt >= gap_limit);

    AST_GAP_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !rise) |=> (gap_cnt != '0)); // R5
endmodule

// File: rtl/rxseq_lock_fsm.sv
// Sequencer state machine with the lock counter.
// OFF -> LOCKING on power-up; LOCKING -> RUN after LOCK_CYCLES edges;
// LOCKING/RUN -> STALL on a gap; STALL -> LOCKING on the next edge.
// Assumes pwr_ok is already synchronous to clk.
module rxseq_lock_fsm import rxseq_pkg::*; #(
    parameter int LOCK_CYCLES = 32800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok,
    input  logic       rise,
    input  logic       gap_over,
    output seq_state_t state
);
    localparam int              LCNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [LCNT_W-1:0] LAST = LCNT_W'(LOCK_CYCLES - 1);

    seq_state_t        state_nx;
    logic [LCNT_W-1:0] lock_cnt, lock_cnt_nx;

    // Next state and next lock count.
    always_comb begin
        state_nx    = state;
        lock_cnt_nx = lock_cnt;
        if (!pwr_ok) begin
            state_nx    = SEQ_OFF;
            lock_cnt_nx = '0;
        end else begin
            unique case (state)
                SEQ_OFF: begin
                    state_nx    = SEQ_LOCKING;
                    lock_cnt_nx = '0;
                end
                SEQ_LOCKING: begin
                    if (rise) begin
                        if (lock_cnt == LAST) begin
                            state_nx    = SEQ_RUN;
                            lock_cnt_nx = '0;
                        end else begin
                            lock_cnt_nx = lock_cnt + 1'b1;
                        end
                    end else if (gap_over) begin
                        state_nx    = SEQ_STALL;
                        lock_cnt_nx = '0;
                    end
                end
                SEQ_RUN: begin
                    if (gap_over) state_nx = SEQ_STALL;
                    lock_cnt_nx = '0;
                end
                SEQ_STALL: begin
                    if (rise) state_nx = SEQ_LOCKING;
                    lock_cnt_nx = '0;
                end
                default: begin
                    state_nx    = SEQ_OFF;
                    lock_cnt_nx = '0;
                end
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_OFF;
            lock_cnt <= '0;
        end else begin
            state    <= state_nx;
            lock_cnt <= lock_cnt_nx;
        end
    end

    AST_POWER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (state == SEQ_OFF)); // R2
    AST_LOCK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_LOCKING && lock_cnt != LAST) |=> (state != SEQ_RUN)); // R4
    AST_STALL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_STALL) |-> (lock_cnt == '0)); // R6
    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SEQ_RUN && state != SEQ_LOCKING) |=> (state != SEQ_RUN)); // R10
endmodule

// File: rtl/rxseq_out_policy.sv
// Output policy: turns the sequencer state, the coding mode and the
// fail-safe flags into registered output enable, PLL run, data and clock.
// Assumes lane_fs, clk_fs, bal_mode and din are synchronous to clk.
module rxseq_out_policy import rxseq_pkg::*; #(
    parameter int LANES = 3,
    parameter int BITS  = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  seq_state_t            state,
    input  logic                  bal_mode,
    input  logic [LANES-1:0]      lane_fs,
    input  logic                  clk_fs,
    input  logic [LANES*BITS-1:0] din,
    input  logic                  fclk_s,
    output logic [LANES*BITS-1:0] dout,
    output logic                  clk_o,
    output logic                  drive_en,
    output logic                  pll_run
);
    localparam int DW = LANES * BITS;

    logic [DW-1:0] masked;
    logic          pass;

    // Per-lane masking: a lane in fail-safe is dropped in plain coding.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic keep;
        assign keep = bal_mode | ~lane_fs[i];
        assign masked[i*BITS +: BITS] = keep ? din[i*BITS +: BITS] : '0;

        AST_LANE_FS: assert property (@(posedge clk) disable iff (!rst_n)
            (!bal_mode && lane_fs[i]) |=> (dout[i*BITS +: BITS] == '0)); // R7
    end

    assign pass = (state == SEQ_RUN) && (bal_mode || !clk_fs);

    // Register the enables and the gated data and clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_en <= 1'b0;
            pll_run  <= 1'b0;
            dout     <= '0;
            clk_o    <= 1'b0;
        end else begin
            drive_en <= (state != SEQ_OFF);
            pll_run  <= (state != SEQ_OFF);
            dout     <= pass ? masked : '0;
            clk_o    <= pass & fclk_s;
        end
    end

    AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> (dout == '0 && !clk_o)); // R2
    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SEQ_RUN) |=> (dout == '0 && !clk_o)); // R3
    AST_CLK_FS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bal_mode && clk_fs) |=> (dout == '0 && !clk_o)); // R8
endmodule

// File: rtl/rx_out_sequencer.sv
// Top of the deserializer output sequencer: synchronises the run pin,
// watches the frame clock, runs the lock state machine and applies the
// output policy. Assumes stall_gap >= 1.
module rx_out_sequencer import rxseq_pkg::*; #(
    parameter int LANES       = 3,
    parameter int BITS        = 7,
    parameter int LOCK_CYCLES = 32800,
    parameter int GAP_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int DW         = LANES * BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_pin,
    input  logic             fclk_lvl,
    input  logic             bal_mode,
    input  logic [LANES-1:0] lane_fs,
    input  logic             clk_fs,
    input  logic [GAP_W-1:0] stall_gap,
    input  logic [DW-1:0]    par_din,
    output logic [DW-1:0]    par_dout,
    output logic             clk_out,
    output logic             drive_en,
    output logic             pll_run
);
    logic       pwr_ok;
    logic       fclk_s;
    logic       rise;
    logic       gap_over;
    seq_state_t state;

    // Reset value 0: an unseen pin counts as powered down.
    rxseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_run_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (run_pin),
        .q     (pwr_ok)
    );

    rxseq_edge_watch #(.STAGES(SYNC_STAGES), .GAP_W(GAP_W)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (state != SEQ_OFF),
        .fclk_lvl  (fclk_lvl),
        .gap_limit (stall_gap),
        .fclk_s    (fclk_s),
        .rise      (rise),
        .gap_over  (gap_over)
    );

    rxseq_lock_fsm #(.LOCK_CYCLES(LOCK_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_ok   (pwr_ok),
        .rise     (rise),
        .gap_over (gap_over),
        .state    (state)
    );

    rxseq_out_policy #(.LANES(LANES), .BITS(BITS)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .bal_mode (bal_mode),
        .lane_fs  (lane_fs),
        .clk_fs   (clk_fs),
        .din      (par_din),
        .fclk_s   (fclk_s),
        .dout     (par_dout),
        .clk_o    (clk_out),
        .drive_en (drive_en),
        .pll_run  (pll_run)
    );

    AST_PLL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_run == drive_en)); // R3
endmodule

// File: tb/rx_out_sequencer_test.sv
module rx_out_sequencer_test;
    localparam int LANES = 3;
    localparam int BITS  = 7;
    localparam int DW    = LANES * BITS;
    localparam int LOCKN = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_pin = 1'b0;
    logic             fclk_lvl = 1'b0;
    logic             bal_mode = 1'b0;
    logic [LANES-1:0] lane_fs = '0;
    logic             clk_fs = 1'b0;
    logic [7:0]       stall_gap = 8'd20;
    logic [DW-1:0]    par_din = '0;
    logic [DW-1:0]    par_dout;
    logic             clk_out, drive_en, pll_run;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  fclk_on = 1'b0;
    int  rise_cnt = 0;

    always #10 clk = ~clk;

    rx_out_sequencer #(.LOCK_CYCLES(LOCKN), .GAP_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .run_pin(run_pin), .fclk_lvl(fclk_lvl),
        .bal_mode(bal_mode), .lane_fs(lane_fs), .clk_fs(clk_fs),
        .stall_gap(stall_gap), .par_din(par_din), .par_dout(par_dout),
        .clk_out(clk_out), .drive_en(drive_en), .pll_run(pll_run)
    );

    // Frame clock: toggles every two reference cycles when enabled.
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk);
            #1;
            if (fclk_on) begin
                ph++;
                if (ph == 2) begin
                    ph = 0;
                    fclk_lvl = ~fclk_lvl;
                    if (fclk_lvl) rise_cnt++;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rises(input int n);
        int base = rise_cnt;
        while (rise_cnt < base + n) @(negedge clk);
        cycles(6);
    endtask

    task automatic drive_word(input logic [DW-1:0] w);
        @(posedge clk); #1;
        par_din = w;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Samples clk_out over 12 cycles; returns 1 if it toggled.
    task automatic clk_toggles(output bit seen);
        bit s0 = 1'b0, s1 = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (clk_out) s1 = 1'b1; else s0 = 1'b1;
        end
        seen = s0 & s1;
    endtask

    task automatic t_reset;
        cycles(3);
        chk("R1 drive_en in reset", 32'(drive_en), 0);
        chk("R1 pll_run in reset", 32'(pll_run), 0);
        @(posedge clk); #1; rst_n = 1'b1;
        cycles(6);
        chk("R1 drive_en pin low", 32'(drive_en), 0);
        chk("R1 dout pin low", 32'(par_dout), 0);
        chk("R1 clk_out pin low", 32'(clk_out), 0);
    endtask

    task automatic t_power_up(input string tag);
        bit tg;
        par_din = 21'h1A5C3E;
        @(posedge clk); #1; run_pin = 1'b1; fclk_on = 1'b1;
        cycles(8);
        chk({tag, " pll_run on"}, 32'(pll_run), 1);
        chk({tag, " drive_en on"}, 32'(drive_en), 1);
        wait_rises(30);
        chk({tag, " dout low before lock"}, 32'(par_dout), 0);
        chk({tag, " clk_out low before lock"}, 32'(clk_out), 0);
        wait_rises(20);
        chk({tag, " dout after lock"}, 32'(par_dout), 32'(21'h1A5C3E));
        clk_toggles(tg);
        chk({tag, " clk_out toggles after lock"}, 32'(tg), 1);
    endtask

    task automatic t_data;
        drive_word(21'h0F0F0F);
        chk("R4 pass pattern 1", 32'(par_dout), 32'(21'h0F0F0F));
        drive_word(21'h1FFFFF);
        chk("R4 pass all ones", 32'(par_dout), 32'(21'h1FFFFF));
        drive_word(21'h000001);
        chk("R4 pass lsb", 32'(par_dout), 32'(21'h000001));
        drive_word(21'h155555);
    endtask

    task automatic t_failsafe_plain;
        bit tg;
        @(posedge clk); #1; bal_mode = 1'b0; lane_fs = 3'b010;
        @(posedge clk); @(negedge clk);
        chk("R7 lane1 dropped", 32'(par_dout), 32'(21'h155555 & ~21'h003F80));
        @(posedge clk); #1; lane_fs = 3'b101;
        @(posedge clk); @(negedge clk);
        chk("R7 lanes 0 and 2 dropped", 32'(par_dout), 32'(21'h155555 & 21'h003F80));
        @(posedge clk); #1; lane_fs = 3'b000; clk_fs = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R8 clock fail-safe data", 32'(par_dout), 0);
        clk_toggles(tg);
        chk("R8 clock fail-safe clk_out", 32'(tg | clk_out), 0);
        @(posedge clk); #1; clk_fs = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R8 release clock fail-safe", 32'(par_dout), 32'(21'h155555));
    endtask

    task automatic t_balanced;
        bit tg;
        @(posedge clk); #1; bal_mode = 1'b1; lane_fs = 3'b111; clk_fs = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R9 balanced ignores fail-safe", 32'(par_dout), 32'(21'h155555));
        clk_toggles(tg);
        chk("R9 balanced clk_out toggles", 32'(tg), 1);
        @(posedge clk); #1; bal_mode = 1'b0; lane_fs = '0; clk_fs = 1'b0;
        cycles(2);
    endtask

    task automatic t_stall;
        @(posedge clk); #1; fclk_on = 1'b0;
        cycles(8);
        chk("R5 short gap no effect", 32'(par_dout), 32'(21'h155555));
        cycles(32);
        chk("R5 stall forces data low", 32'(par_dout), 0);
        chk("R5 stall keeps drive_en", 32'(drive_en), 1);
        chk("R5 stall clk_out low", 32'(clk_out), 0);
        @(posedge clk); #1; fclk_on = 1'b1;
        wait_rises(25);
        chk("R6 relock from zero", 32'(par_dout), 0);
        wait_rises(25);
        chk("R6 data after relock", 32'(par_dout), 32'(21'h155555));
    endtask

    task automatic t_power_down;
        @(posedge clk); #1; run_pin = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R2 drive_en off within 4 edges", 32'(drive_en), 0);
        chk("R2 pll_run off within 4 edges", 32'(pll_run), 0);
        chk("R2 dout quiet in power-down", 32'(par_dout), 0);
        cycles(10);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_power_up("R3 R4");
        t_data();
        t_failsafe_plain();
        t_balanced();
        t_stall();
        t_power_down();
        t_power_up("R10");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule